// File: doc/BRIEF.md
# Activity Speedup Throttle Override Timer

This block sits beside the clock-throttling logic of a power manager. The power manager slows the CPU by modulating its suspend request. While the system is busy, that throttling should be lifted for a while. The block watches two classes of activity and holds a throttle-inhibit output high for a programmed number of prescaler ticks after the most recent qualifying event. The suspend handshake logic reads that output and stops modulating the clock while it is high.

The interrupt class reacts to any interrupt request whose mask bit is clear, and to an SMI pulse. The video class reacts to a strobe from the video status link, and to bus accesses that fall inside the legacy VGA windows. Those windows are the I/O ports 3B0h to 3DFh and the memory range A0000h to B7FFFh. Each class has its own enable and its own reload value, and keeps its own down-counter.

Software picks the durations. The prescaler input `tick` sets the time base: one pulse consumes one unit of every running count.

Top module: `speedup_override`

## Requirements
- R1: After reset both class counters are zero and `inhibit` is low.
- R2: With `irq_en` high, a cycle in which some bit of `irq_req` is 1 while the same bit of `irq_mask` is 0 (mask bit 1 means masked), or in which `smi_evt` is 1, loads `irq_reload` into the interrupt counter at that clock edge. If `irq_reload` is nonzero, `inhibit` is high in the following cycle.
- R3: With `vid_en` high, a cycle in which `vid_strobe` is 1 loads `vid_reload` into the video counter at that clock edge.
- R4: A cycle with `bus_valid`=1 and `bus_is_io`=1 counts as video activity exactly when `bus_addr` lies between 3B0h and 3DFh inclusive, with all bits above bit 15 zero.
- R5: A cycle with `bus_valid`=1 and `bus_is_io`=0 counts as video activity exactly when `bus_addr` lies between A0000h and B7FFFh inclusive. When `bus_valid`=0, no address counts.
- R6: A nonzero counter decreases by one on each clock edge at which `tick` is 1 and its class has no event. Without `tick` it holds. After a load of N with no further events, `inhibit` therefore stays high for exactly N ticks and falls only on a tick edge.
- R7: A new qualifying event while a counter is running reloads that counter, so the full duration restarts.
- R8: `inhibit` is high exactly while at least one class counter is nonzero. It rises only after a qualifying event.
- R9: A reload value of zero means an event of that class never raises `inhibit`.
- R10: If a class's enable is 0 at a clock edge, that class's counter is zero after that edge.
- R11: Events of a disabled class, and masked interrupt requests, leave `inhibit` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler enable; one pulse consumes one count unit |
| irq_en | input | 1 | Enable for the interrupt/SMI class |
| vid_en | input | 1 | Enable for the video class |
| irq_reload | input | CNT_W | Duration loaded on an interrupt-class event |
| vid_reload | input | CNT_W | Duration loaded on a video-class event |
| irq_req | input | IRQ_W | Interrupt request lines |
| irq_mask | input | IRQ_W | Interrupt mask, 1 = masked |
| smi_evt | input | 1 | SMI event pulse |
| vid_strobe | input | 1 | Video activity from the status link |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| bus_addr | input | ADDR_W | Bus access address |
| inhibit | output | 1 | Throttle inhibit to the suspend handshake |

## Verification
A counter stuck at a wrong value shows on `inhibit` as a duration that is longer or shorter than the programmed number of ticks. The bench measures every duration in whole ticks, so an off-by-one shows at the first measurement. A decode error in the VGA windows shows in the very next cycle, because the bench sweeps every I/O port below 800h and every 4 KiB step of the first megabyte, plus both edges of each window. A wrong enable, mask or priority path shows within one cycle of the stimulus, either as `inhibit` failing to rise or as `inhibit` failing to clear.

// File: rtl/speedup_override_pkg.sv
package speedup_override_pkg;
   typedef enum int unsigned {
      CLS_IRQ = 0,
      CLS_VID = 1
   } act_class_e;
   localparam int unsigned NUM_CLS = 2;
   localparam logic [19:0] VGA_MEM_LO = 20'hA0000;
   localparam logic [19:0] VGA_MEM_HI = 20'hB7FFF;
   localparam logic [11:0] VGA_IO_LO  = 12'h03B;
   localparam logic [11:0] VGA_IO_HI  = 12'h03D;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
   parameter int unsigned IRQ_W = 16
) (
   input  logic [IRQ_W-1:0] req,
   input  logic [IRQ_W-1:0] mask,
   input  logic             smi,
   output logic             hit
);
   always_comb hit = (|(req & ~mask)) | smi;
endmodule

// File: rtl/vga_window_decode.sv
module vga_window_decode
   import speedup_override_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              valid,
   input  logic              is_io,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] MEM_LO = ADDR_W'(VGA_MEM_LO);
   localparam logic [ADDR_W-1:0] MEM_HI = ADDR_W'(VGA_MEM_HI);

   logic io_hit, mem_hit;

   always_comb begin
      io_hit  = (addr[ADDR_W-1:16] == '0) &&
                (addr[15:4] >= VGA_IO_LO) && (addr[15:4] <= VGA_IO_HI);
      mem_hit = (addr >= MEM_LO) && (addr <= MEM_HI);
      hit     = valid && (is_io ? io_hit : mem_hit);
   end
endmodule

// File: rtl/speedup_counter.sv
module speedup_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             evt,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt;
      if (!en)
         cnt_d = '0;
      else if (evt)
         cnt_d = reload;
      else if (tick && (cnt != '0))
         cnt_d = cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_d;
   end
endmodule

// File: rtl/speedup_override.sv
module speedup_override
   import speedup_override_pkg::*;
#(
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned IRQ_W      = 16,
   parameter int unsigned ADDR_W     = 32,
   parameter bit          VGA_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              irq_en,
   input  logic              vid_en,
   input  logic [CNT_W-1:0]  irq_reload,
   input  logic [CNT_W-1:0]  vid_reload,
   input  logic [IRQ_W-1:0]  irq_req,
   input  logic [IRQ_W-1:0]  irq_mask,
   input  logic              smi_evt,
   input  logic              vid_strobe,
   input  logic              bus_valid,
   input  logic              bus_is_io,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              inhibit
);
   if (CNT_W < 1)   begin : g_bad_cnt  $error("CNT_W must be at least 1");   end
   if (IRQ_W < 1)   begin : g_bad_irq  $error("IRQ_W must be at least 1");   end
   if (ADDR_W < 20) begin : g_bad_addr $error("ADDR_W must be at least 20"); end

   logic [NUM_CLS-1:0]            cls_en;
   logic [NUM_CLS-1:0]            cls_evt;
   logic [NUM_CLS-1:0][CNT_W-1:0] cls_reload;
   logic [NUM_CLS-1:0][CNT_W-1:0] cls_cnt;
   logic [NUM_CLS-1:0]            cls_busy;
   logic                          irq_hit, vga_hit;

   irq_qualify #(.IRQ_W(IRQ_W)) u_irq_q (
      .req(irq_req), .mask(irq_mask), .smi(smi_evt), .hit(irq_hit)
   );

   if (VGA_DECODE) begin : g_vga
      vga_window_decode #(.ADDR_W(ADDR_W)) u_vga (
         .valid(bus_valid), .is_io(bus_is_io), .addr(bus_addr), .hit(vga_hit)
      );
   end else begin : g_no_vga
      assign vga_hit = 1'b0;
   end

   always_comb begin
      cls_en[CLS_IRQ]     = irq_en;
      cls_en[CLS_VID]     = vid_en;
      cls_evt[CLS_IRQ]    = irq_hit;
      cls_evt[CLS_VID]    = vid_strobe | vga_hit;
      cls_reload[CLS_IRQ] = irq_reload;
      cls_reload[CLS_VID] = vid_reload;
   end

   for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      speedup_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .en(cls_en[c]), .evt(cls_evt[c]),
         .tick(tick), .reload(cls_reload[c]), .cnt(cls_cnt[c])
      );
      assign cls_busy[c] = (cls_cnt[c] != '0);
   end

   assign inhibit = |cls_busy;
endmodule

// File: rtl/speedup_override_chk.sv
module speedup_override_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  tick,
   input logic                  irq_en,
   input logic                  vid_en,
   input logic [CNT_W-1:0]      irq_reload,
   input logic [CNT_W-1:0]      vid_reload,
   input logic [1:0]            cls_evt,
   input logic [1:0][CNT_W-1:0] cls_cnt,
   input logic                  inhibit
);
   a_r2_irq_load: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en && cls_evt[0] |=> cls_cnt[0] == $past(irq_reload));

   a_r3_vid_load: assert property (@(posedge clk) disable iff (!rst_n)
      vid_en && cls_evt[1] |=> cls_cnt[1] == $past(vid_reload));

   a_r6_irq_step: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en && !cls_evt[0] && tick && cls_cnt[0] != '0
      |=> cls_cnt[0] == $past(cls_cnt[0]) - 1'b1);

   a_r6_vid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      vid_en && !cls_evt[1] && !tick |=> $stable(cls_cnt[1]));

   a_r8_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inhibit) |-> $past((irq_en && cls_evt[0]) || (vid_en && cls_evt[1])));

   a_r9_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en && cls_evt[0] && irq_reload == '0 |=> cls_cnt[0] == '0);

   a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> cls_cnt[0] == '0);

   a_r10_vid_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !vid_en |=> cls_cnt[1] == '0);
endmodule

bind speedup_override speedup_override_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .irq_en(irq_en), .vid_en(vid_en),
   .irq_reload(irq_reload), .vid_reload(vid_reload), .cls_evt(cls_evt),
   .cls_cnt(cls_cnt), .inhibit(inhibit)
);

// File: tb/speedup_override_bench.sv
module speedup_override_bench;
   localparam int unsigned CNT_W = 8, IRQ_W = 16, ADDR_W = 32;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, irq_en = 1'b0, vid_en = 1'b0;
   logic [CNT_W-1:0] irq_reload = '0, vid_reload = '0;
   logic [IRQ_W-1:0] irq_req = '0, irq_mask = '0;
   logic smi_evt = 1'b0, vid_strobe = 1'b0, bus_valid = 1'b0, bus_is_io = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic inhibit;
   int vectors = 0, errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   speedup_override #(.CNT_W(CNT_W), .IRQ_W(IRQ_W), .ADDR_W(ADDR_W)) u_speedup_override (
      .clk(clk), .rst_n(rst_n), .tick(tick), .irq_en(irq_en), .vid_en(vid_en),
      .irq_reload(irq_reload), .vid_reload(vid_reload), .irq_req(irq_req),
      .irq_mask(irq_mask), .smi_evt(smi_evt), .vid_strobe(vid_strobe),
      .bus_valid(bus_valid), .bus_is_io(bus_is_io), .bus_addr(bus_addr),
      .inhibit(inhibit));

   task automatic check(string req, int act, int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   endtask

   // Drops both enables for one edge, then restores them.
   task automatic clear_all();
      logic ie, ve;
      ie = irq_en; ve = vid_en;
      irq_en = 1'b0; vid_en = 1'b0; tick = 1'b0;
      @(negedge clk);
      irq_en = ie; vid_en = ve;
   endtask

   task automatic pulse(input bit irq, input bit vid);
      smi_evt = irq; vid_strobe = vid;
      @(negedge clk);
      smi_evt = 1'b0; vid_strobe = 1'b0;
   endtask

   // Counts tick edges until inhibit falls; tick fires every 'period' cycles.
   task automatic measure(string req, int exp, int period);
      int ticks = 0;
      bool_loop: for (int i = 0; i < 1000; i++) begin
         tick = ((i % period) == period - 1);
         @(negedge clk);
         if (tick) ticks++;
         if (!inhibit) begin
            if (!tick) check({req, " fell without tick"}, 1, 0);
            break;
         end
      end
      tick = 1'b0;
      check(req, ticks, exp);
   endtask

   task automatic bus_probe(string req, bit io, logic [ADDR_W-1:0] a, bit valid, bit exp);
      bus_valid = valid; bus_is_io = io; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      check(req, int'(inhibit), int'(exp));
      clear_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 inhibit in reset", int'(inhibit), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 inhibit after reset", int'(inhibit), 0);

      // R6/R2/R3: durations for every reload 0..20, two tick rates, both classes
      irq_en = 1'b1; vid_en = 1'b1;
      for (int n = 0; n <= 20; n++) begin
         for (int p = 1; p <= 2; p++) begin
            irq_reload = CNT_W'(n); vid_reload = '0;
            pulse(1'b1, 1'b0);
            if (n == 0) check("R9 irq zero reload", int'(inhibit), 0);
            else begin
               check("R2 smi starts override", int'(inhibit), 1);
               measure("R6 irq duration", n, p);
            end
            irq_reload = '0; vid_reload = CNT_W'(n);
            pulse(1'b0, 1'b1);
            if (n == 0) check("R9 vid zero reload", int'(inhibit), 0);
            else begin
               check("R3 strobe starts override", int'(inhibit), 1);
               measure("R6 vid duration", n, p);
            end
            clear_all();
         end
      end

      // R6: no tick means no countdown
      irq_reload = 8'd2; pulse(1'b1, 1'b0);
      repeat (30) @(negedge clk);
      check("R6 hold without tick", int'(inhibit), 1);
      measure("R6 hold then count", 2, 1);

      // R2/R11: each interrupt line alone, masked and unmasked
      irq_reload = 8'd1;
      for (int b = 0; b < IRQ_W; b++) begin
         irq_req = IRQ_W'(1) << b;
         irq_mask = IRQ_W'(1) << b;
         @(negedge clk);
         check("R11 masked irq ignored", int'(inhibit), 0);
         irq_mask = ~(IRQ_W'(1) << b);
         @(negedge clk);
         irq_req = '0;
         check("R2 unmasked irq line", int'(inhibit), 1);
         clear_all();
      end
      irq_mask = '0;

      // R7: retrigger restarts full duration
      irq_reload = 8'd5; pulse(1'b1, 1'b0);
      tick = 1'b1; repeat (3) @(negedge clk); tick = 1'b0;
      pulse(1'b1, 1'b0);
      measure("R7 retrigger restarts", 5, 1);

      // R8: OR of both classes
      irq_reload = 8'd2; vid_reload = 8'd6; pulse(1'b1, 1'b1);
      measure("R8 longer video wins", 6, 1);
      irq_reload = 8'd7; vid_reload = 8'd3; pulse(1'b1, 1'b1);
      measure("R8 longer irq wins", 7, 1);

      // R10: clearing enable clears counter
      irq_reload = 8'd10; pulse(1'b1, 1'b0);
      irq_en = 1'b0; @(negedge clk);
      check("R10 irq disable clears", int'(inhibit), 0);
      irq_en = 1'b1; @(negedge clk);
      check("R10 stays clear after re-enable", int'(inhibit), 0);
      vid_reload = 8'd10; pulse(1'b0, 1'b1);
      vid_en = 1'b0; @(negedge clk);
      check("R10 vid disable clears", int'(inhibit), 0);

      // R11: disabled classes ignore events
      vid_en = 1'b0; irq_en = 1'b0;
      pulse(1'b1, 1'b1);
      check("R11 disabled classes", int'(inhibit), 0);
      irq_req = 16'h0001; @(negedge clk); irq_req = '0;
      check("R11 disabled irq line", int'(inhibit), 0);
      bus_probe("R11 disabled vga", 1'b1, 32'h3C0, 1'b1, 1'b0);

      // R4: I/O sweep 000h..7FFh
      vid_en = 1'b1; vid_reload = 8'd1;
      for (int a = 0; a < 'h800; a++)
         bus_probe("R4 io window", 1'b1, ADDR_W'(a), 1'b1, (a >= 'h3B0) && (a <= 'h3DF));
      bus_probe("R4 io upper bits", 1'b1, 32'h0001_03C0, 1'b1, 1'b0);
      bus_probe("R4 io not memory", 1'b0, 32'h3C0, 1'b1, 1'b0);

      // R5: memory sweep in 4 KiB steps plus window edges
      for (int k = 0; k < 256; k++)
         bus_probe("R5 mem window", 1'b0, ADDR_W'(k) << 12, 1'b1,
                   ((k << 12) >= 'hA0000) && ((k << 12) <= 'hB7FFF));
      bus_probe("R5 below window", 1'b0, 32'h9FFFF, 1'b1, 1'b0);
      bus_probe("R5 low edge",     1'b0, 32'hA0000, 1'b1, 1'b1);
      bus_probe("R5 high edge",    1'b0, 32'hB7FFF, 1'b1, 1'b1);
      bus_probe("R5 above window", 1'b0, 32'hB8000, 1'b1, 1'b0);
      bus_probe("R5 high alias",   1'b0, 32'h100A0000, 1'b1, 1'b0);
      bus_probe("R5 io flag on mem", 1'b1, 32'hA0000, 1'b1, 1'b0);
      bus_probe("R5 no valid",     1'b0, 32'hA8000, 1'b0, 1'b0);

      // R5 memory access then duration through the decode path
      vid_reload = 8'd4;
      bus_valid = 1'b1; bus_is_io = 1'b0; bus_addr = 32'hB0000;
      @(negedge clk); bus_valid = 1'b0;
      measure("R5 mem hit duration", 4, 1);

      finish_run();
   end
endmodule